// File: doc/BRIEF.md
# Masked Level Interrupt Collector

This block gathers four level-sensitive interrupt requests from board devices into one interrupt line toward a host processor. Each request is synchronised into the block's clock, then held in a per-source pending flag. The flag stays set until the host acknowledges it and the source has gone quiet. A host-writable enable register chooses which pending flags may drive the shared line. The host watches that line for a rising edge, so the line must drop once nothing enabled is pending. A later event then gives a fresh edge.

The host reaches the block through a 16-bit register port with an address, write data, a write strobe and combinational read data. Address 0 holds the enable register, where a one enables a source. Address 1 holds the status register. It uses inverted polarity: a pending source reads as zero and an idle source reads as one. Writing a one to a status bit acknowledges that source. The host finds pending work as the inverse of the status AND the enable. It handles the lowest-numbered source first and re-reads until nothing enabled is pending. A typical start-up writes 0x00 to the enable register and 0xFF to the status register.

Each source runs a two-state machine:
- SRC_IDLE moves to SRC_PEND when the synchronised level is high (transition "raise").
- SRC_PEND returns to SRC_IDLE on an acknowledge while the synchronised level is low (transition "clear").
- Each state otherwise holds.

The output machine also has two states:
- OUT_QUIET moves to OUT_RAISED when any enabled source is pending (transition "fire").
- OUT_RAISED returns to OUT_QUIET when none is (transition "drop").

Top module: `irq_aggr`

## Requirements
- R1: After reset the enable register reads 0x0000, the status register reads 0x00FF and `irq_o` is low.
- R2: A write to address 0 stores write-data bits 3..0 as the enable bits, and they read back at address 0 in bits 3..0.
- R3: A source held high at the input drives its status bit (bit n for source n) to zero by the third rising clock edge that samples it high.
- R4: A write to address 1 with bit n set returns status bit n to one at that edge if the synchronised level of source n is low.
- R5: When the synchronised level of source n is high, status bit n is zero at the next edge even if the same cycle writes a one to bit n.
- R6: Writing a zero to a status bit has no effect on it.
- R7: `irq_o` is high one clock after any bit of (~status & enable) is set, and low one clock after none is.
- R8: A masked source still shows as pending in the status register but does not raise `irq_o`.
- R9: Status bits 7..4 read as one; enable bits 15..4 and status bits 15..8 read as zero; writes do not change them. Addresses 2 and 3 read zero and ignore writes.
- R10: A pending status bit stays zero after its source drops, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 4 | Level interrupt requests, active high, asynchronous |
| addr_i | input | 2 | Register address (0 enable, 1 status) |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt toward the host, active high |

## Verification
The hardest case to reach from the ports is an acknowledge that lands while the synchronised copy of a source is still high, even though the raw input has already dropped. The acknowledge must then be lost, and the host has to ack again. The bench drives this on purpose. It releases a source and writes the acknowledge in the next cycle, before the two synchroniser stages have emptied. A long pseudo-random phase then mixes source toggles, acknowledges and enable writes. A behavioural model tracks the synchroniser depth and is compared against `irq_o` and the read data on every clock.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    // Register addresses; the host driver depends on these two offsets.
    localparam int unsigned ADDR_ENA  = 0;
    localparam int unsigned ADDR_STAT = 1;

    // Per-source pending tracker.
    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_state_e;

    // Combined output line.
    typedef enum logic {
        OUT_QUIET  = 1'b0,
        OUT_RAISED = 1'b1
    } out_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
    import irq_aggr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,    // synchronised source level
    input  logic ack_i,    // host wrote a one to this status bit
    output logic idle_o    // status bit: 1 idle, 0 pending
);

    src_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (lvl_i)           state_d = SRC_PEND;   // raise
            SRC_PEND: if (ack_i && !lvl_i) state_d = SRC_IDLE;   // clear
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        idle_o = (state_q == SRC_IDLE);
    end

endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_aggr_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] live_i,  // enabled and pending
    output logic               irq_o
);

    out_state_e state_q, state_d;
    logic       any_live;

    assign any_live = |live_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_QUIET:  if (any_live)  state_d = OUT_RAISED;  // fire
            OUT_RAISED: if (!any_live) state_d = OUT_QUIET;   // drop
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == OUT_RAISED);
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_aggr_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2,
    parameter int VIEW_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] stat_i,
    output logic [NUM_SRC-1:0] ena_o,
    output logic [NUM_SRC-1:0] ack_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ADDR_ENA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

    logic [NUM_SRC-1:0] ena_q;
    logic               hit_ena, hit_stat;

    assign hit_ena  = (addr_i == A_ENA);
    assign hit_stat = (addr_i == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ena_q <= '0;
        else if (wr_i && hit_ena)  ena_q <= wdata_i[NUM_SRC-1:0];
    end

    assign ena_o = ena_q;
    assign ack_o = (wr_i && hit_stat) ? wdata_i[NUM_SRC-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        if (hit_ena) begin
            rdata_o[NUM_SRC-1:0] = ena_q;
        end else if (hit_stat) begin
            rdata_o[VIEW_W-1:0]  = '1;
            rdata_o[NUM_SRC-1:0] = stat_i;
        end
    end

endmodule

// File: rtl/irq_aggr.sv
module irq_aggr #(
    parameter int NUM_SRC     = 4,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 2,
    parameter int VIEW_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               wr_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] ena_q;
    logic [NUM_SRC-1:0] ack_w;
    logic [NUM_SRC-1:0] live_w;

    irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    generate
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            irq_src_fsm u_src (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (src_sync[n]),
                .ack_i  (ack_w[n]),
                .idle_o (stat_q[n])
            );
        end
    endgenerate

    irq_regs #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .VIEW_W  (VIEW_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wr_i    (wr_i),
        .stat_i  (stat_q),
        .ena_o   (ena_q),
        .ack_o   (ack_w),
        .rdata_o (rdata_o)
    );

    assign live_w = ~stat_q & ena_q;

    irq_out_fsm #(.NUM_SRC(NUM_SRC)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .live_i (live_w),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_sync,
    input logic [NUM_SRC-1:0] stat_q,
    input logic [NUM_SRC-1:0] ena_q,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic               wr_i,
    input logic [DATA_W-1:0]  rdata_o,
    input logic               irq_o
);

    logic stat_wr;
    assign stat_wr = wr_i && (addr_i == ADDR_W'(1));

    // R7: output follows enabled pending set one clock later
    a_r7_irq_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~stat_q & ena_q)) |=> irq_o);

    // R7: output drops one clock after nothing enabled is pending
    a_r7_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(~stat_q & ena_q)) |=> !irq_o);

    // R5: an active synchronised level always leaves the bit pending
    a_r5_level_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_sync) |=> ((stat_q & $past(src_sync)) == '0));

    // R4: acknowledge of a quiet source returns the bit to one
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && |(wdata_i[NUM_SRC-1:0] & ~src_sync)) |=>
        ((stat_q & $past(wdata_i[NUM_SRC-1:0] & ~src_sync)) ==
         $past(wdata_i[NUM_SRC-1:0] & ~src_sync)));

    // R10: without a status write, pending bits stay pending
    a_r10_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((~stat_q & $past(~stat_q)) == $past(~stat_q)));

    // R9: upper byte of read data is always zero
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i || !wr_i |-> (rdata_o[DATA_W-1:8] == '0));

endmodule

bind irq_aggr irq_aggr_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sync (src_sync),
    .stat_q   (stat_q),
    .ena_q    (ena_q),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_i     (wr_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o)
);

// File: tb/test_irq_aggr.sv
`timescale 1ns/1ps
module test_irq_aggr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_i = '0;
    logic [1:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        wr_i = 1'b0;
    logic [15:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit compare_on = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    irq_aggr i_irq_aggr (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wr_i    (wr_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // ---------------- behavioural reference model ----------------
    bit [3:0] syncq[$];
    bit [3:0] m_stat;
    bit [3:0] m_ena;
    bit       m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syncq = {4'h0, 4'h0};
            m_stat = 4'hF;
            m_ena = 4'h0;
            m_irq = 1'b0;
        end else begin
            bit [3:0] lvl;
            bit [3:0] nstat;
            bit       nirq;
            lvl = syncq[1];
            nirq = ((~m_stat & m_ena) != 4'h0);
            for (int i = 0; i < 4; i++) begin
                if (lvl[i])                                           nstat[i] = 1'b0;
                else if (wr_i && addr_i == 2'd1 && wdata_i[i] == 1'b1) nstat[i] = 1'b1;
                else                                                  nstat[i] = m_stat[i];
            end
            if (wr_i && addr_i == 2'd0) m_ena = wdata_i[3:0];
            m_stat = nstat;
            m_irq = nirq;
            void'(syncq.pop_back());
            syncq.push_front(src_i);
        end
    end

    function automatic logic [15:0] model_read(input logic [1:0] a);
        if (a == 2'd0) return {12'h000, m_ena};
        if (a == 2'd1) return {8'h00, 4'hF, m_stat};
        return 16'h0000;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model (R7 line, R9/R2 read view)
    always @(negedge clk) begin
        if (compare_on) begin
            check(irq_o == m_irq, "R7 irq vs model", {15'h0, irq_o}, {15'h0, m_irq});
            check(rdata_o == model_read(addr_i), "R9 rdata vs model", rdata_o,
                  model_read(addr_i));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk); #1;
        wr_i = 1'b0; wdata_i = '0;
    endtask

    task automatic expect_read(input logic [1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); #1;
        addr_i = a;
        @(negedge clk);
        check(rdata_o == exp, tag, rdata_o, exp);
        #1;
    endtask

    task automatic expect_irq(input logic exp, input string tag);
        @(negedge clk);
        check(irq_o == exp, tag, {15'h0, irq_o}, {15'h0, exp});
        #1;
    endtask

    // watchdog
    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        step(3);
        rst_n = 1'b1;
        step(1);
        compare_on = 1'b1;

        // R1 reset state
        expect_irq(1'b0, "R1 irq after reset");
        expect_read(2'd0, 16'h0000, "R1 enable after reset");
        expect_read(2'd1, 16'h00FF, "R1 status after reset");

        // host init sequence, then R2 / R9 enable view
        write_reg(2'd0, 16'h0000);
        write_reg(2'd1, 16'h00FF);
        write_reg(2'd0, 16'hFFFF);
        expect_read(2'd0, 16'h000F, "R2 enable readback, R9 upper enable bits");

        // R3 source 0 raises
        src_i = 4'b0001;
        step(3);
        expect_read(2'd1, 16'h00FE, "R3 status bit0 pending");
        expect_irq(1'b1, "R7 irq raised");

        // R10 latched after source drops
        src_i = 4'b0000;
        step(4);
        expect_read(2'd1, 16'h00FE, "R10 pending held after source drop");

        // R6 writing zero does nothing
        write_reg(2'd1, 16'h0000);
        expect_read(2'd1, 16'h00FE, "R6 zero write ignored");

        // R4 acknowledge clears, R7 irq drops
        write_reg(2'd1, 16'h0001);
        expect_read(2'd1, 16'h00FF, "R4 ack returns bit to one");
        expect_irq(1'b0, "R7 irq dropped");

        // R5 ack while source 1 held
        src_i = 4'b0010;
        step(4);
        write_reg(2'd1, 16'h0002);
        expect_read(2'd1, 16'h00FD, "R5 pending wins over ack");

        // R5 ack one cycle after raw drop, synchroniser still high
        src_i = 4'b0000;
        write_reg(2'd1, 16'h0002);
        expect_read(2'd1, 16'h00FD, "R5 ack lost during sync drain");

        // R8 masked source still pending, irq quiet
        write_reg(2'd0, 16'h0001);
        step(2);
        expect_irq(1'b0, "R8 masked pending no irq");
        expect_read(2'd1, 16'h00FD, "R8 masked still visible");
        write_reg(2'd0, 16'h0002);
        step(1);
        expect_irq(1'b1, "R8 unmask raises irq");
        write_reg(2'd1, 16'h0002);
        step(1);
        expect_irq(1'b0, "R7 fresh drop before next edge");

        // R9 reserved status bits and spare addresses
        write_reg(2'd1, 16'hFF00);
        expect_read(2'd1, 16'h00FF, "R9 upper status bits");
        write_reg(2'd2, 16'hFFFF);
        write_reg(2'd3, 16'hFFFF);
        expect_read(2'd2, 16'h0000, "R9 spare address 2");
        expect_read(2'd3, 16'h0000, "R9 spare address 3");
        expect_read(2'd0, 16'h0002, "R9 spare writes left enable alone");

        // pseudo-random phase compared against the model every clock
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) src_i = lfsr[7:4];
            wr_i = (lfsr[10:9] == 2'b00);
            addr_i = lfsr[12:11];
            wdata_i = {lfsr[3:0], lfsr[15:4]};
        end
        wr_i = 1'b0;
        step(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule